// File: doc/BRIEF.md
# Phase Count and Control Mode Selector

This block sits in the digital core of a multi-phase buck regulator controller. It decides how many power phases switch and which control method they use. Two board straps give the configured phase count, and four live inputs reduce it when the load is light: a power-state indicator, a deep-sleep request, a flag that is high while a voltage-code change settles, and an over-current flag. The decision is registered. It appears on the outputs one clock after the inputs that caused it.

A master-clock tick drives a rotating phase pointer. On every tick, exactly one of the active phases gets a one-cycle clock-enable pulse, in the order 1, 2, ... N and then back to 1. Each phase therefore runs at the master rate divided by the active count, and the phases are interleaved. When the active count changes, the pointer restarts at phase 1. A separate output keeps the third phase's external driver switched off unless three phases are running and the block is enabled.

Top module: `phase_mode_sel`

## Requirements
- R1: The straps encode the configured count as `strap_cfg` = 2'b00 → 1 phase, 2'b01 → 1 phase (graphics-rail mode), 2'b10 → 2 phases, 2'b11 → 3 phases; this count is what "all configured phases" means below.
- R2: While `vid_busy` is high, the block selects all configured phases, PWM (`rpm_mode`=0) and `dcm_en`=0, whatever the other inputs are.
- R3: With `vid_busy` low, `deep_sleep` low and `pwr_state` high, the block selects all configured phases, PWM, `dcm_en`=0.
- R4: With `vid_busy`, `deep_sleep` and `pwr_state` all low, the block selects 1 phase in RPM (`rpm_mode`=1) with `dcm_en`=0; if `ilim_hit` is high it selects all configured phases, PWM, `dcm_en`=0 instead.
- R5: With `vid_busy` low and `deep_sleep` high, the block selects 1 phase; the mode is RPM with `dcm_en`=1, or PWM with `dcm_en`=0 when `ilim_hit` is high.
- R6: With `strap_cfg`=2'b01 the active count is 1 in every input combination.
- R7: `ph3_drv_en` is 1 only while the active count is 3 and `run_en` is high; it is 0 in single-phase operation and while `run_en` is low.
- R8: `ph_clk_en` is zero in every cycle where `tick` or `run_en` is low. In a cycle with both high, exactly the bit of the current phase is set (bit 0 = phase 1), and the pointer steps through the active phases in ascending order and wraps to phase 1.
- R9: A change of the active count, or `run_en` low, returns the pointer to phase 1 at the same clock edge.
- R10: Reset (`rst_n` low, asynchronous) sets the active count to 1, PWM, `dcm_en`=0, `ph3_drv_en`=0 and the pointer to phase 1. After reset, every decision output reflects the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_en | input | 1 | Block enable; low means shutdown |
| strap_cfg | input | 2 | Static phase-count strap (R1 encoding) |
| pwr_state | input | 1 | Power-state indicator; low requests light-load operation |
| deep_sleep | input | 1 | Deep-sleep request |
| vid_busy | input | 1 | High during a voltage-code transition window |
| ilim_hit | input | 1 | Over-current flag |
| tick | input | 1 | Master-clock tick, one cycle wide |
| act_phases | output | CNT_W | Active phase count (1 to 3) |
| rpm_mode | output | 1 | 1 = RPM control, 0 = PWM control |
| dcm_en | output | 1 | Automatic discontinuous conduction allowed |
| ph3_drv_en | output | 1 | Third-phase driver enable; low disables it |
| ph_clk_en | output | MAX_PH | Per-phase clock-enable pulses, one-hot |

## Verification
Every strap setting is crossed with all sixteen combinations of power-state, deep-sleep, transition and over-current. This separates the priority layers: the transition flag overrides the rest, deep sleep overrides power-state, and over-current restores PWM only in some rows. A long stretch of steady ticks at three phases checks the order and the wrap of the rotation. A change of the phase count in the middle of a rotation shows whether the pointer restarts. Random tick gaps and a shutdown window confirm that no enable pulse appears without both a tick and the enable.

// File: rtl/pms_pkg.sv
package pms_pkg;
   typedef enum logic {
      CTRL_PWM = 1'b0,
      CTRL_RPM = 1'b1
   } ctrl_e;

   localparam logic [1:0] STRAP_ONE  = 2'b00;
   localparam logic [1:0] STRAP_GFX  = 2'b01;
   localparam logic [1:0] STRAP_TWO  = 2'b10;
   localparam logic [1:0] STRAP_THREE = 2'b11;

   // configured phase count from the strap pair
   function automatic int unsigned strap_count(input logic [1:0] s);
      case (s)
         STRAP_TWO:   return 2;
         STRAP_THREE: return 3;
         default:     return 1;
      endcase
   endfunction
endpackage

// File: rtl/pms_decide.sv
module pms_decide
   import pms_pkg::*;
#(
   parameter int CNT_W = 2
) (
   input  logic [1:0]       strap_cfg,
   input  logic             pwr_state,
   input  logic             deep_sleep,
   input  logic             vid_busy,
   input  logic             ilim_hit,
   output logic [CNT_W-1:0] cnt_next,
   output ctrl_e            ctrl_next,
   output logic             dcm_next
);
   logic [CNT_W-1:0] full_cnt;

   assign full_cnt = CNT_W'(strap_count(strap_cfg));

   always_comb begin
      cnt_next  = full_cnt;
      ctrl_next = CTRL_PWM;
      dcm_next  = 1'b0;
      if (vid_busy) begin
         cnt_next = full_cnt;
      end else if (deep_sleep) begin
         cnt_next = CNT_W'(1);
         if (!ilim_hit) begin
            ctrl_next = CTRL_RPM;
            dcm_next  = 1'b1;
         end
      end else if (!pwr_state && !ilim_hit) begin
         cnt_next  = CNT_W'(1);
         ctrl_next = CTRL_RPM;
      end
   end
endmodule

// File: rtl/pms_rotor.sv
module pms_rotor #(
   parameter int MAX_PH = 3,
   parameter int CNT_W  = $clog2(MAX_PH + 1),
   localparam int PTR_W = (MAX_PH > 1) ? $clog2(MAX_PH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_en,
   input  logic              tick,
   input  logic [CNT_W-1:0]  cnt_cur,
   input  logic [CNT_W-1:0]  cnt_next,
   output logic [MAX_PH-1:0] ph_clk_en
);
   logic [PTR_W-1:0] ptr_q;
   logic             fire;
   logic             at_last;

   assign fire    = run_en && tick;
   assign at_last = (CNT_W'(ptr_q) == cnt_cur - CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (!run_en || (cnt_next != cnt_cur)) begin
         ptr_q <= '0;
      end else if (tick) begin
         ptr_q <= at_last ? '0 : ptr_q + PTR_W'(1);
      end
   end

   for (genvar i = 0; i < MAX_PH; i++) begin : g_lane
      assign ph_clk_en[i] = fire && (ptr_q == PTR_W'(i));
   end

   // R8
   ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      CNT_W'(ptr_q) < cnt_cur);

   // R9
   ptr_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_next != cnt_cur) |=> (ptr_q == '0));
endmodule

// File: rtl/phase_mode_sel.sv
module phase_mode_sel
   import pms_pkg::*;
#(
   parameter int MAX_PH = 3,
   localparam int CNT_W = $clog2(MAX_PH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_en,
   input  logic [1:0]        strap_cfg,
   input  logic              pwr_state,
   input  logic              deep_sleep,
   input  logic              vid_busy,
   input  logic              ilim_hit,
   input  logic              tick,
   output logic [CNT_W-1:0]  act_phases,
   output logic              rpm_mode,
   output logic              dcm_en,
   output logic              ph3_drv_en,
   output logic [MAX_PH-1:0] ph_clk_en
);
   if (MAX_PH < 3) begin : g_bad_cfg
      $error("phase_mode_sel: MAX_PH must be at least 3");
   end

   logic [CNT_W-1:0] cnt_next, cnt_q;
   ctrl_e            ctrl_next, ctrl_q;
   logic             dcm_next, dcm_q, ph3_q;

   pms_decide #(.CNT_W(CNT_W)) u_decide (
      .strap_cfg (strap_cfg),
      .pwr_state (pwr_state),
      .deep_sleep(deep_sleep),
      .vid_busy  (vid_busy),
      .ilim_hit  (ilim_hit),
      .cnt_next  (cnt_next),
      .ctrl_next (ctrl_next),
      .dcm_next  (dcm_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= CNT_W'(1);
         ctrl_q <= CTRL_PWM;
         dcm_q  <= 1'b0;
         ph3_q  <= 1'b0;
      end else begin
         cnt_q  <= cnt_next;
         ctrl_q <= ctrl_next;
         dcm_q  <= dcm_next;
         ph3_q  <= run_en && (cnt_next == CNT_W'(3));
      end
   end

   pms_rotor #(.MAX_PH(MAX_PH), .CNT_W(CNT_W)) u_rotor (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_en   (run_en),
      .tick     (tick),
      .cnt_cur  (cnt_q),
      .cnt_next (cnt_next),
      .ph_clk_en(ph_clk_en)
   );

   assign act_phases = cnt_q;
   assign rpm_mode   = (ctrl_q == CTRL_RPM);
   assign dcm_en     = dcm_q;
   assign ph3_drv_en = ph3_q;

   // R5
   dcm_needs_rpm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dcm_en |-> rpm_mode);

   // R4
   rpm_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rpm_mode |-> (act_phases == CNT_W'(1)));

   // R7
   ph3_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ph3_drv_en |-> (act_phases == CNT_W'(3)));

   // R2
   vid_pwm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vid_busy |=> (!rpm_mode && !dcm_en));

   // R6
   gfx_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (strap_cfg == STRAP_GFX) |=> (act_phases == CNT_W'(1)));

   // R8
   lane_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ph_clk_en));

   // R8
   no_tick_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick || !run_en) |-> (ph_clk_en == '0));
endmodule

// File: tb/phase_mode_sel_bench.sv
module phase_mode_sel_bench;
   localparam int PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       run_en = 1'b0;
   logic [1:0] strap_cfg = 2'b00;
   logic       pwr_state = 1'b0;
   logic       deep_sleep = 1'b0;
   logic       vid_busy = 1'b0;
   logic       ilim_hit = 1'b0;
   logic       tick = 1'b0;
   logic [1:0] act_phases;
   logic       rpm_mode, dcm_en, ph3_drv_en;
   logic [2:0] ph_clk_en;

   int checks = 0;
   int errs   = 0;
   bit done   = 0;
   string cur_req = "R10";

   // reference model state
   int m_cnt = 1, m_rpm = 0, m_dcm = 0, m_ph3 = 0, m_ptr = 0;

   phase_mode_sel u_phase_mode_sel (
      .clk(clk), .rst_n(rst_n), .run_en(run_en), .strap_cfg(strap_cfg),
      .pwr_state(pwr_state), .deep_sleep(deep_sleep), .vid_busy(vid_busy),
      .ilim_hit(ilim_hit), .tick(tick), .act_phases(act_phases),
      .rpm_mode(rpm_mode), .dcm_en(dcm_en), .ph3_drv_en(ph3_drv_en),
      .ph_clk_en(ph_clk_en)
   );

   always #(PERIOD/2) clk = ~clk;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt = 1; m_rpm = 0; m_dcm = 0; m_ph3 = 0; m_ptr = 0;
      end else begin
         int full, nc, nr, nd;
         full = (strap_cfg == 2'b11) ? 3 : (strap_cfg == 2'b10) ? 2 : 1;
         nc = full; nr = 0; nd = 0;
         if (vid_busy) begin
            nc = full;
         end else if (deep_sleep) begin
            nc = 1; nr = ilim_hit ? 0 : 1; nd = nr;
         end else if (!pwr_state && !ilim_hit) begin
            nc = 1; nr = 1;
         end
         if (!run_en || nc != m_cnt) m_ptr = 0;
         else if (tick) m_ptr = (m_ptr + 1) % m_cnt;
         m_cnt = nc; m_rpm = nr; m_dcm = nd;
         m_ph3 = (run_en && nc == 3) ? 1 : 0;
      end
   end

   task automatic cmp(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic cycle();
      int exp_en;
      string en_req;
      @(negedge clk);
      en_req = (cur_req == "R9" || cur_req == "R10") ? cur_req : "R8";
      exp_en = (run_en && tick) ? (1 << m_ptr) : 0;
      cmp(cur_req, "act_phases", int'(act_phases), m_cnt);
      cmp(cur_req, "rpm_mode", int'(rpm_mode), m_rpm);
      cmp(cur_req, "dcm_en", int'(dcm_en), m_dcm);
      cmp((cur_req == "R10") ? "R10" : "R7", "ph3_drv_en", int'(ph3_drv_en), m_ph3);
      cmp(en_req, "ph_clk_en", int'(ph_clk_en), exp_en);
   endtask

   initial begin
      #(PERIOD * 150000);
      if (!done) begin
         errs++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      // R10: reset state
      repeat (3) cycle();
      rst_n = 1'b1;
      run_en = 1'b1;

      // R1..R6: every strap crossed with every live-input combination
      for (int s = 0; s < 4; s++) begin
         for (int c = 0; c < 16; c++) begin
            strap_cfg  = s[1:0];
            vid_busy   = c[3];
            deep_sleep = c[2];
            pwr_state  = c[1];
            ilim_hit   = c[0];
            if (s == 1) cur_req = "R6";
            else if (c[3]) cur_req = "R2";
            else if (c[2]) cur_req = "R5";
            else if (c[1]) cur_req = (s >= 2) ? "R1" : "R3";
            else cur_req = "R4";
            for (int k = 0; k < 6; k++) begin
               tick = 1'($urandom_range(0, 1));
               cycle();
            end
         end
      end

      // R8: steady rotation over three phases with continuous ticks
      cur_req = "R8";
      strap_cfg = 2'b11; pwr_state = 1'b1; deep_sleep = 1'b0;
      vid_busy = 1'b0; ilim_hit = 1'b0; tick = 1'b1;
      for (int k = 0; k < 12; k++) cycle();
      strap_cfg = 2'b10;
      for (int k = 0; k < 8; k++) cycle();

      // R9: count change in mid rotation restarts at phase 1
      cur_req = "R9";
      strap_cfg = 2'b11;
      for (int k = 0; k < 3; k++) cycle();
      deep_sleep = 1'b1;
      for (int k = 0; k < 3; k++) cycle();
      deep_sleep = 1'b0;
      for (int k = 0; k < 5; k++) cycle();
      vid_busy = 1'b1; pwr_state = 1'b0;
      for (int k = 0; k < 4; k++) cycle();

      // R7: shutdown silences third phase and all enables
      cur_req = "R3";
      vid_busy = 1'b0; pwr_state = 1'b1;
      run_en = 1'b0;
      for (int k = 0; k < 5; k++) cycle();
      run_en = 1'b1;
      for (int k = 0; k < 6; k++) cycle();

      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule